// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns one 6-bit operand code of a 16-bit-word processor into a concrete operand. The result can be a general-register select, a memory address, a special-register select or an immediate value. It also reports how the stack pointer and the program counter move because of this operand. Some modes carry an extra word in the instruction stream. For those modes the decoder raises a fetch request and waits for the surrounding sequencer to hand that word back with a one-cycle valid pulse. The memory, the arithmetic unit and instruction sequencing are outside this block.

A decode starts with a one-cycle `start` pulse that carries `code` and `skip`. When no extension word is needed, the result appears with `done` high on the next cycle. When an extension word is needed, `ext_req` rises on the next cycle and stays high until the cycle in which `ext_valid` is seen. The result then appears with `done` on the following cycle. The register file and stack pointer inputs are sampled in the cycle in which the decode completes: the start cycle, or the cycle in which `ext_valid` is high. Results stay on the outputs until the next completion. In skip mode the decoder only reports how far the program counter must advance, so that a skipped instruction is stepped over with its full length.

Top module: `opnd_decoder`

## Requirements
- R1: Codes 0x00 to 0x07 give kind REG (1), with `sel` equal to the low three bits of the code (0=A, 1=B, 2=C, 3=X, 4=Y, 5=Z, 6=I, 7=J). `done` rises one cycle after `start`.
- R2: Codes 0x08 to 0x0f give kind MEM (2), with `data` equal to the value of the register chosen by the low three bits. Register n sits at `reg_file[16n+15:16n]`.
- R3: Codes 0x10 to 0x17 request one extension word. They give kind MEM, with `data` equal to that word plus the chosen register, modulo 2^16, and `pc_adv` set to 1.
- R4: Stack modes give kind MEM. Code 0x18 gives address `sp_val` and `sp_inc`=01 (+1). Code 0x19 gives address `sp_val` and `sp_inc`=00. Code 0x1a gives address `sp_val`-1 modulo 2^16 and `sp_inc`=11 (-1). All other codes give `sp_inc`=00.
- R5: Codes 0x1b, 0x1c and 0x1d give kind SPECIAL (3), with `sel` 0 (stack pointer), 1 (program counter) and 2 (overflow register) respectively.
- R6: Code 0x1e requests an extension word and gives kind MEM with that word as the address. Code 0x1f requests an extension word and gives kind LIT (4) with that word as the value. Both set `pc_adv`=1.
- R7: Codes 0x20 to 0x3f give kind LIT, with `data` equal to the code minus 0x20 and `pc_adv`=0.
- R8: `wr_ignore` is 1 for every LIT result and 0 for every other result that is not skipped.
- R9: With `skip` high, the result has kind NONE (0), `sp_inc`=00 and `wr_ignore`=1, and it arrives one cycle after `start` with no `ext_req`. `pc_adv` is 1 exactly for codes 0x10 to 0x17, 0x1e and 0x1f.
- R10: `ext_req` is high from the cycle after a start that needs a word until the cycle in which `ext_valid` is seen. `done` follows one cycle after that. `start`, `code` and `skip` are ignored while the decoder waits.
- R11: After reset, `done` and `ext_req` are 0.
- R12: Fields not used by a kind read 0: `sel` for MEM, LIT and NONE, and `data` for REG, SPECIAL and NONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding `code` |
| code | input | 6 | Operand code |
| skip | input | 1 | Decode for length only |
| reg_file | input | 8*DW | Eight general registers, register n at bits 16n+15:16n |
| sp_val | input | DW | Current stack pointer |
| ext_word | input | DW | Extension word from the instruction stream |
| ext_valid | input | 1 | Extension word is present this cycle |
| ext_req | output | 1 | Extension word wanted |
| done | output | 1 | Result valid this cycle |
| kind | output | 3 | 0 NONE, 1 REG, 2 MEM, 3 SPECIAL, 4 LIT |
| sel | output | 3 | Register or special-register index |
| data | output | DW | Effective address or literal value |
| wr_ignore | output | 1 | Writes aimed at this operand are discarded |
| sp_inc | output | 2 | Stack pointer change, two's complement |
| pc_adv | output | 1 | Program counter advances by one extension word |

## Verification
The hardest case to reach is a new `start` arriving while the decoder is still waiting for an extension word. Here the decoder must keep the code it captured and use the register values present when the word arrives. The stimulus holds `start` high with random codes during variable-length waits before pulsing `ext_valid`. It also changes the register file between operations. Stack wrap is reached by setting the stack pointer to 0 before a push. Index wrap is reached by pairing a register of 0xffff with a nonzero extension word.

// File: rtl/opnd_decoder.sv
module opnd_decoder #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [5:0]    code,
  input  logic          skip,
  input  logic [8*DW-1:0] reg_file,
  input  logic [DW-1:0] sp_val,
  input  logic [DW-1:0] ext_word,
  input  logic          ext_valid,
  output logic          ext_req,
  output logic          done,
  output logic [2:0]    kind,
  output logic [2:0]    sel,
  output logic [DW-1:0] data,
  output logic          wr_ignore,
  output logic [1:0]    sp_inc,
  output logic          pc_adv
);
  localparam logic [2:0] K_NONE = 3'd0;
  localparam logic [2:0] K_REG  = 3'd1;
  localparam logic [2:0] K_MEM  = 3'd2;
  localparam logic [2:0] K_SPEC = 3'd3;
  localparam logic [2:0] K_LIT  = 3'd4;

  logic          busy;
  logic [5:0]    held;
  logic [DW-1:0] rsel;
  logic [2:0]    n_kind, n_sel;
  logic [DW-1:0] n_data;
  logic          n_ign, n_pc;
  logic [1:0]    n_sp;

  wire [5:0]    cur      = busy ? held : code;
  wire          cur_skip = busy ? 1'b0 : skip;
  wire          need_ext = (cur[5:3] == 3'b010) || (cur == 6'h1e) || (cur == 6'h1f);
  wire [DW-1:0] ext_in   = busy ? ext_word : '0;
  wire          fire     = busy ? ext_valid : (start && (skip || !need_ext));
  wire          go_wait  = !busy && start && !skip && need_ext;

  assign ext_req = busy;

  always_comb rsel = reg_file[DW*int'(cur[2:0]) +: DW];

  always_comb begin
    n_kind = K_NONE;
    n_sel  = '0;
    n_data = '0;
    n_ign  = 1'b1;
    n_sp   = 2'b00;
    n_pc   = need_ext;
    if (!cur_skip) begin
      n_ign = 1'b0;
      if (cur[5]) begin
        n_kind = K_LIT;
        n_data = DW'(cur[4:0]);
        n_ign  = 1'b1;
      end else begin
        case (cur[4:3])
          2'd0: begin n_kind = K_REG; n_sel = cur[2:0]; end
          2'd1: begin n_kind = K_MEM; n_data = rsel; end
          2'd2: begin n_kind = K_MEM; n_data = ext_in + rsel; end
          default: begin
            case (cur[2:0])
              3'd0: begin n_kind = K_MEM; n_data = sp_val; n_sp = 2'b01; end
              3'd1: begin n_kind = K_MEM; n_data = sp_val; end
              3'd2: begin n_kind = K_MEM; n_data = sp_val - DW'(1); n_sp = 2'b11; end
              3'd6: begin n_kind = K_MEM; n_data = ext_in; end
              3'd7: begin n_kind = K_LIT; n_data = ext_in; n_ign = 1'b1; end
              default: begin n_kind = K_SPEC; n_sel = cur[2:0] - 3'd3; end
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      held      <= '0;
      done      <= 1'b0;
      kind      <= K_NONE;
      sel       <= '0;
      data      <= '0;
      wr_ignore <= 1'b0;
      sp_inc    <= 2'b00;
      pc_adv    <= 1'b0;
    end else begin
      done <= fire;
      if (go_wait) begin
        busy <= 1'b1;
        held <= code;
      end else if (busy && ext_valid) begin
        busy <= 1'b0;
      end
      if (fire) begin
        kind      <= n_kind;
        sel       <= n_sel;
        data      <= n_data;
        wr_ignore <= n_ign;
        sp_inc    <= n_sp;
        pc_adv    <= n_pc;
      end
    end
  end

  assert_lit_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == K_LIT) |-> wr_ignore);
  assert_stack_only_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sp_inc != 2'b00) |-> (kind == K_MEM));
  assert_skip_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == K_NONE) |-> (sp_inc == 2'b00 && wr_ignore));
  assert_no_req_on_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && skip && !ext_req) |=> !ext_req);
  assert_word_then_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_valid) |=> (done && pc_adv && !ext_req));
  assert_reg_no_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (kind == K_REG || kind == K_SPEC)) |-> (data == '0));
endmodule

// File: tb/test_opnd_decoder.sv
`timescale 1ns/1ps
module test_opnd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  code = '0;
  logic        skip = 1'b0;
  logic [127:0] reg_file;
  logic [15:0] sp_val = '0;
  logic [15:0] ext_word = '0;
  logic        ext_valid = 1'b0;
  logic        ext_req, done, wr_ignore, pc_adv;
  logic [2:0]  kind, sel;
  logic [15:0] data;
  logic [1:0]  sp_inc;

  logic [15:0] r [8];
  always_comb for (int k = 0; k < 8; k++) reg_file[16*k +: 16] = r[k];

  int total = 0;
  int bad = 0;
  bit armed = 1'b0;

  always #4 clk = ~clk;

  opnd_decoder i_opnd_decoder (
    .clk(clk), .rst_n(rst_n), .start(start), .code(code), .skip(skip),
    .reg_file(reg_file), .sp_val(sp_val), .ext_word(ext_word), .ext_valid(ext_valid),
    .ext_req(ext_req), .done(done), .kind(kind), .sel(sel), .data(data),
    .wr_ignore(wr_ignore), .sp_inc(sp_inc), .pc_adv(pc_adv));

  // reference model state
  bit      m_busy = 0;
  int      m_code = 0;
  bit      e_done = 0, e_req = 0;
  int      e_kind = 0, e_sel = 0, e_data = 0, e_ign = 0, e_sp = 0, e_pc = 0;
  string   e_tag = "R1";
  bit      e_skip = 0;

  function automatic bit wants_word(int c);
    return (c >= 16 && c <= 23) || c == 30 || c == 31;
  endfunction

  function automatic string tag_of(int c, bit s);
    if (s) return "R9";
    if (c < 8) return "R1";
    if (c < 16) return "R2";
    if (c < 24) return "R3";
    if (c < 27) return "R4";
    if (c < 30) return "R5";
    if (c < 32) return "R6";
    return "R7";
  endfunction

  task automatic model_result(int c, bit s, int w);
    e_tag = tag_of(c, s); e_skip = s;
    e_kind = 0; e_sel = 0; e_data = 0; e_ign = 1; e_sp = 0;
    e_pc = wants_word(c) ? 1 : 0;
    if (s) return;
    e_ign = 0;
    if (c >= 32) begin e_kind = 4; e_data = c - 32; e_ign = 1; end
    else if (c < 8) begin e_kind = 1; e_sel = c; end
    else if (c < 16) begin e_kind = 2; e_data = r[c - 8]; end
    else if (c < 24) begin e_kind = 2; e_data = (w + r[c - 16]) % 65536; end
    else if (c == 24) begin e_kind = 2; e_data = sp_val; e_sp = 1; end
    else if (c == 25) begin e_kind = 2; e_data = sp_val; end
    else if (c == 26) begin e_kind = 2; e_data = (sp_val + 65535) % 65536; e_sp = 3; end
    else if (c == 30) begin e_kind = 2; e_data = w; end
    else if (c == 31) begin e_kind = 4; e_data = w; e_ign = 1; end
    else begin e_kind = 3; e_sel = c - 27; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; e_done = 0;
    end else begin
      e_done = 0;
      if (!m_busy) begin
        if (start) begin
          if (!skip && wants_word(code)) begin m_busy = 1; m_code = code; end
          else begin model_result(code, skip, 0); e_done = 1; end
        end
      end else if (ext_valid) begin
        model_result(m_code, 0, ext_word);
        m_busy = 0; e_done = 1;
      end
    end
    e_req = m_busy;
    if (!rst_n) armed = 1'b1;
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (armed && rst_n) begin
    chk("R10", "done", done, e_done);
    chk("R10", "ext_req", ext_req, e_req);
    if (e_done) begin
      chk(e_tag, "kind", kind, e_kind);
      chk((e_kind == 1 || e_kind == 3) ? e_tag : "R12", "sel", sel, e_sel);
      chk((e_kind == 2 || e_kind == 4) ? e_tag : "R12", "data", data, e_data);
      chk(e_skip ? "R9" : "R8", "wr_ignore", wr_ignore, e_ign);
      chk(e_skip ? "R9" : "R4", "sp_inc", sp_inc, e_sp);
      chk(e_skip ? "R9" : e_tag, "pc_adv", pc_adv, e_pc);
    end
  end

  task automatic op(input int c, input bit s, input int dly, input bit poke, input logic [15:0] w);
    @(negedge clk); start = 1'b1; code = 6'(c); skip = s;
    @(negedge clk); start = 1'b0; code = 6'($urandom); skip = 1'($urandom);
    if (!s && wants_word(c)) begin
      for (int k = 0; k < dly; k++) begin
        start = poke;
        code = 6'($urandom);
        r[k % 8] = 16'($urandom);
        @(negedge clk);
      end
      start = 1'b0;
      ext_word = w; ext_valid = 1'b1;
      @(negedge clk); ext_valid = 1'b0; ext_word = 16'($urandom);
    end
    @(negedge clk);
  endtask

  task automatic shuffle();
    for (int k = 0; k < 8; k++) r[k] = 16'($urandom);
    sp_val = 16'($urandom);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    shuffle();
    repeat (3) @(negedge clk);
    chk("R11", "reset done", done, 0);
    chk("R11", "reset ext_req", ext_req, 0);
    rst_n = 1'b1;
    for (int c = 0; c < 64; c++) begin shuffle(); op(c, 0, c % 3, 0, 16'($urandom)); end
    for (int c = 0; c < 64; c++) begin shuffle(); op(c, 1, 1, 0, 16'($urandom)); end
    sp_val = 16'h0000; op(26, 0, 0, 0, 0);
    sp_val = 16'hffff; op(24, 0, 0, 0, 0);
    r[3] = 16'hffff; op(19, 0, 0, 0, 16'h0002);
    for (int d = 0; d < 4; d++) begin
      shuffle(); op(16 + d, 0, d + 1, 1, 16'($urandom));
      shuffle(); op(30, 0, d, 1, 16'($urandom));
      shuffle(); op(31, 0, d, 1, 16'hbeef);
    end
    for (int n = 0; n < 200; n++) begin
      shuffle(); op(int'($urandom % 64), 1'($urandom), int'($urandom % 4), 1'($urandom), 16'($urandom));
    end
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule